// File: doc/BRIEF.md
# DMA event latch and dispatch

This block collects DMA request events and hands them to a transfer controller one at a time. There are 64 events. A one-cycle pulse on an event's hardware set line latches a pending flag. A 64-bit enable mask decides which pending events may be served. Among the pending events that are also enabled, the lowest-numbered one is issued as a transfer request on a valid/acknowledge handshake that carries the 6-bit event number. When the controller acknowledges the request, the block clears that event's pending flag.

Software reaches the block through a small register bus with word addresses and a valid/ready handshake. Software can read the pending flags, and it can read and write the enable mask; both are split into a low word (events 0-31) and a high word (events 32-63). Two write-only clear words give write-one-to-clear access to the pending flags. A disabled event is never issued, so these clear words are the only way to remove a disabled event's pending flag. A flag never clears on its own.

Top module: `dma_event_dispatch`

## Requirements
- R1: After reset, all pending flags and all enable bits are 0 and `req_valid` is 0.
- R2: A high `evt_set[n]` at a clock edge sets pending flag n. Reading address 0 returns flags 0-31, with bit n being event n. Reading address 1 returns flags 32-63, with bit n being event 32+n.
- R3: A pending flag stays set until its request is acknowledged or software clears it.
- R4: Writing to address 4 clears pending flag n for every bit n of the write data that is 1. Writing to address 5 clears flag 32+n for every bit n that is 1. Bits written as 0 leave their flags unchanged.
- R5: Reads of the clear words (addresses 4 and 5) return 0. Reads of the unused addresses 6 and 7 return 0.
- R6: Addresses 2 and 3 hold the enable mask for events 0-31 and events 32-63. Both words can be read and written, with bit n of address 3 being event 32+n.
- R7: A request is issued only for an event that is both pending and enabled. A disabled pending event stays pending and is never issued.
- R8: When several enabled events are pending, the request carries the lowest event number.
- R9: Once `req_valid` is high, it stays high with `req_evt` unchanged until the cycle in which `req_ack` is high.
- R10: An acknowledge clears the pending flag of `req_evt` and drops `req_valid`. The next request can be raised at the following clock edge.
- R11: If a set pulse and a clear (a software write or an acknowledge) hit the same event at the same edge, the flag ends up set.
- R12: `bus_ready` is always 1. A write takes effect at the clock edge where `bus_valid` and `bus_write` are high. Read data is valid in the same cycle as `bus_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_set | input | 64 | Hardware set pulses, bit n for event n |
| bus_valid | input | 1 | Register access valid |
| bus_ready | output | 1 | Register access accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address: 0/1 pending, 2/3 enable, 4/5 clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| req_valid | output | 1 | Transfer request outstanding |
| req_evt | output | 6 | Event number of the request |
| req_ack | input | 1 | Transfer request accepted |

## Verification
Assertions check the following on every cycle:
- A waiting request holds steady.
- An acknowledge removes the flag it names.
- No flag falls without a clear.
- A set pulse always lands.
- No request appears while nothing is both pending and enabled.
- The clear words read as 0.

Some behaviours can only be shown by the bench's scenarios: lowest-number selection among several ready events, exact bit positions in the high word, the effect of all-zero clear writes, and the ordering of back-to-back requests after each acknowledge. The bench's reference model checks these against the outputs and read data on every clock.

// File: rtl/dma_event_dispatch.sv
`timescale 1ns/1ps
module dma_event_dispatch #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 3,
  localparam int NUM_EVT = 2 * WORD_W,
  localparam int IDX_W = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_set,
  input  logic               bus_valid,
  output logic               bus_ready,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic               req_valid,
  output logic [IDX_W-1:0]   req_evt,
  input  logic               req_ack
);
  localparam logic [ADDR_W-1:0] A_PEND_LO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PEND_HI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_EN_LO   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_EN_HI   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CLR_LO  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CLR_HI  = ADDR_W'(5);
  localparam logic [WORD_W-1:0] ZW = '0;

  logic [NUM_EVT-1:0] pend_q, en_q, sw_clr, ack_clr, ready_vec;
  logic [IDX_W-1:0]   pick;
  logic               wr, fire;

  assign bus_ready = 1'b1;
  assign wr        = bus_valid & bus_write;
  assign fire      = req_valid & req_ack;
  assign sw_clr    = {(wr && bus_addr == A_CLR_HI) ? bus_wdata : ZW,
                      (wr && bus_addr == A_CLR_LO) ? bus_wdata : ZW};
  assign ack_clr   = fire ? ({{(NUM_EVT-1){1'b0}}, 1'b1} << req_evt) : '0;
  assign ready_vec = pend_q & en_q;

  always_comb begin
    pick = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--)
      if (ready_vec[i]) pick = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= evt_set | (pend_q & ~sw_clr & ~ack_clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr) begin
      if (bus_addr == A_EN_LO) en_q[WORD_W-1:0]       <= bus_wdata;
      if (bus_addr == A_EN_HI) en_q[NUM_EVT-1:WORD_W] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_evt   <= '0;
    end else if (fire) begin
      req_valid <= 1'b0;
    end else if (!req_valid && |ready_vec) begin
      req_valid <= 1'b1;
      req_evt   <= pick;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (bus_addr)
        A_PEND_LO: bus_rdata = pend_q[WORD_W-1:0];
        A_PEND_HI: bus_rdata = pend_q[NUM_EVT-1:WORD_W];
        A_EN_LO:   bus_rdata = en_q[WORD_W-1:0];
        A_EN_HI:   bus_rdata = en_q[NUM_EVT-1:WORD_W];
        default:   bus_rdata = '0;
      endcase
    end
  end

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_evt)));

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack && !evt_set[req_evt]) |=> !pend_q[$past(req_evt)]);

  a_r3_no_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(sw_clr | ack_clr)) == '0));

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> (($past(evt_set) & ~pend_q) == '0));

  a_r7_no_idle_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && ((pend_q & en_q) == '0)) |=> !req_valid);

  a_r5_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && (bus_addr == A_CLR_LO || bus_addr == A_CLR_HI))
      |-> (bus_rdata == '0));
endmodule

// File: tb/dma_event_dispatch_tb.sv
`timescale 1ns/1ps
module dma_event_dispatch_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [63:0] evt_set = '0;
  logic        bus_valid = 0, bus_write = 0, req_ack = 0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, req_valid;
  logic [31:0] bus_rdata;
  logic [5:0]  req_evt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_event_dispatch dut_i (.clk(clk), .rst_n(rst_n), .evt_set(evt_set),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_valid(req_valid), .req_evt(req_evt), .req_ack(req_ack));

  logic [63:0] m_pend, m_en;
  bit m_rv;
  int m_re;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_pend[31:0];
      3'd1: return m_pend[63:32];
      3'd2: return m_en[31:0];
      3'd3: return m_en[63:32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_en = '0; m_rv = 0; m_re = 0;
    end else begin
      logic [63:0] clr;
      bit fire;
      int pick;
      fire = m_rv && req_ack;
      pick = -1;
      for (int i = 63; i >= 0; i--) if (m_pend[i] && m_en[i]) pick = i;
      clr = '0;
      if (bus_valid && bus_write && bus_addr == 3'd4) clr[31:0] = bus_wdata;
      if (bus_valid && bus_write && bus_addr == 3'd5) clr[63:32] = bus_wdata;
      if (fire) clr[m_re] = 1'b1;
      if (bus_valid && bus_write && bus_addr == 3'd2) m_en[31:0] = bus_wdata;
      if (bus_valid && bus_write && bus_addr == 3'd3) m_en[63:32] = bus_wdata;
      m_pend = evt_set | (m_pend & ~clr);
      if (fire) m_rv = 0;
      else if (!m_rv && pick >= 0) begin m_rv = 1; m_re = pick; end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R9 R10 model req_valid", {63'b0, req_valid}, {63'b0, m_rv});
      if (m_rv) check("R8 R9 model req_evt", {58'b0, req_evt}, 64'(m_re));
      if (bus_valid && !bus_write) check("R12 model rdata", {32'b0, bus_rdata}, {32'b0, m_read(bus_addr)});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    #1; check("R12 bus_ready", {63'b0, bus_ready}, 64'd1);
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a;
    #1; check(tag, {32'b0, bus_rdata}, {32'b0, exp});
    @(negedge clk); bus_valid = 0;
  endtask

  task automatic pulse(input logic [63:0] v);
    @(negedge clk); evt_set = v;
    @(negedge clk); evt_set = '0;
  endtask

  task automatic ack();
    @(negedge clk); req_ack = 1;
    @(negedge clk); req_ack = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1);
    check("R1 req_valid after reset", {63'b0, req_valid}, 64'd0);
    rd(3'd0, 32'h0, "R1 pending low");
    rd(3'd1, 32'h0, "R1 pending high");
    rd(3'd2, 32'h0, "R1 enable low");
    rd(3'd3, 32'h0, "R1 enable high");

    pulse((64'd1 << 3) | (64'd1 << 40));
    rd(3'd0, 32'h0000_0008, "R2 pending low bit 3");
    rd(3'd1, 32'h0000_0100, "R2 pending high event 40");
    idle(6);
    rd(3'd0, 32'h0000_0008, "R3 flag held");
    check("R7 disabled not issued", {63'b0, req_valid}, 64'd0);

    wr(3'd4, 32'h0);
    rd(3'd0, 32'h0000_0008, "R4 zero write no effect");
    wr(3'd4, 32'h0000_0008);
    rd(3'd0, 32'h0, "R4 clear low");
    wr(3'd5, 32'h0000_0100);
    rd(3'd1, 32'h0, "R4 clear high event 40");

    @(negedge clk); evt_set = 64'd1 << 7; bus_valid = 1; bus_write = 1; bus_addr = 3'd4; bus_wdata = 32'h80;
    @(negedge clk); evt_set = '0; bus_valid = 0; bus_write = 0;
    rd(3'd0, 32'h0000_0080, "R11 set beats software clear");
    wr(3'd4, 32'h80);

    rd(3'd4, 32'h0, "R5 clear low reads zero");
    rd(3'd5, 32'h0, "R5 clear high reads zero");
    rd(3'd7, 32'h0, "R5 unused reads zero");

    wr(3'd2, 32'hF0F0_0001);
    rd(3'd2, 32'hF0F0_0001, "R6 enable low readback");
    rd(3'd3, 32'h0, "R6 enable high untouched");
    pulse(64'd1 << 3);
    idle(4);
    check("R7 disabled event 3 not issued", {63'b0, req_valid}, 64'd0);
    rd(3'd0, 32'h0000_0008, "R7 disabled stays pending");
    wr(3'd4, 32'h8);

    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, 32'hFFFF_FFFF, "R6 enable high readback");
    pulse((64'd1 << 9) | (64'd1 << 4) | (64'd1 << 33));
    idle(2);
    check("R8 lowest valid", {63'b0, req_valid}, 64'd1);
    check("R8 lowest event", {58'b0, req_evt}, 64'd4);
    idle(5);
    check("R9 held event", {58'b0, req_evt}, 64'd4);
    check("R9 held valid", {63'b0, req_valid}, 64'd1);
    ack();
    check("R10 valid drops", {63'b0, req_valid}, 64'd0);
    rd(3'd0, 32'h0000_0200, "R10 acked flag cleared");
    check("R10 next request", {58'b0, req_evt}, 64'd9);

    @(negedge clk); req_ack = 1; evt_set = 64'd1 << 9;
    @(negedge clk); req_ack = 0; evt_set = '0;
    rd(3'd0, 32'h0000_0200, "R11 set beats ack");
    check("R11 event reissued", {58'b0, req_evt}, 64'd9);
    ack();
    idle(1);
    check("R8 high event next", {58'b0, req_evt}, 64'd33);
    rd(3'd1, 32'h0000_0002, "R2 event 33 high bit 1");
    ack();
    idle(2);
    check("R10 all served", {63'b0, req_valid}, 64'd0);
    rd(3'd1, 32'h0, "R10 high cleared");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule